// File: doc/BRIEF.md
# CAN Error-Confinement Status Unit

This block keeps the transmit and receive error counters of a CAN node and turns them into four status flags: a reset-state flag, a transmission-idle flag, an error-warning flag and a bus-off flag. A protocol engine drives it with single-cycle strobes for error increments and decrements, for bit positions inside End Of Frame and intermission, and for arbitration loss, bus idle, reception start, halt entry and detected runs of 11 recessive bits. The block returns a 4-bit status word, an 8-bit view of each counter and a transmit-acknowledge pulse.

The transmit counter is 9 bits wide, and its top bit is the bus-off state. While the node is off the bus, normal error accounting stops. The receive counter is reused to count 11-recessive-bit runs until recovery. Because the receive counter climbs during this phase, the warning flag is held low for its whole duration. The transmit acknowledge and the return of the idle flag are tied to different bit positions of the frame tail.

Top module: `can_fault_status`

## Requirements
- R1: After `rst_n` low or a `sw_reset` pulse, `in_reset` reads 1, `tx_idle` reads 1, warning and bus-off read 0 and both counters read 0. A pulse on `init_done` clears `in_reset` on the next edge. While `in_reset` is 1, counter events and `tx_start` have no effect.
- R2: `status` has this layout: bit 0 is in_reset, bit 1 is tx_idle, bit 2 is warning and bit 3 is bus_off. `tec_view` shows the lower 8 bits of the 9-bit transmit counter, and `rec_view` shows the receive counter.
- R3: A `tx_start` pulse outside reset and bus off makes `tx_idle` read 0 from the next cycle. It stays 0 while error increments arrive during the transmission.
- R4: `tx_ack` is a one-cycle pulse in the cycle after a `bit_tick` with `field_sel`=1 (End Of Frame) and `bit_num`=7, while a transmission is in progress. Other bit numbers give no pulse.
- R5: `tx_idle` returns to 1 after a `bit_tick` with `field_sel`=2 (intermission) and `bit_num`=3, provided `tx_pending` is low. With `tx_pending` high, or at any other bit number, it stays 0.
- R6: A pulse on `arb_lost`, `bus_idle`, `rx_start` or `halt_req` makes `tx_idle` read 1 on the next cycle.
- R7: `tx_inc_amt`/`rx_inc_amt` are added when their enable is high. A decrement lowers a counter by 1 and stops at 0. If an increment and a decrement reach the same counter in one cycle, the increment wins. The receive counter saturates at 255 outside bus off.
- R8: Outside bus off, the warning flag is 1 exactly when either counter is at least 96.
- R9: When an increment takes the transmit counter to 256 or above, bus-off takes effect. The transmit counter holds 256, so `tec_view` reads 0. The receive counter is cleared, `tx_idle` reads 0, and error increments and decrements are ignored.
- R10: In bus off, each `rec11_seen` pulse adds 1 to the receive counter, and the warning flag stays 0 even when that count reaches 96.
- R11: On the 128th `rec11_seen` pulse in bus off, both counters become 0, bus-off reads 0 and `tx_idle` reads 1.
- R12: `sw_reset` takes priority over every other event in the same cycle, including bus-off recovery counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_reset | input | 1 | Software internal reset pulse |
| init_done | input | 1 | Leave the reset state |
| tx_inc_en | input | 1 | Add `tx_inc_amt` to the transmit counter |
| tx_inc_amt | input | 4 | Transmit increment amount |
| tx_dec | input | 1 | Decrement transmit counter by 1 |
| rx_inc_en | input | 1 | Add `rx_inc_amt` to the receive counter |
| rx_inc_amt | input | 4 | Receive increment amount |
| rx_dec | input | 1 | Decrement receive counter by 1 |
| rec11_seen | input | 1 | A run of 11 recessive bits was detected |
| tx_start | input | 1 | A transmission begins |
| tx_pending | input | 1 | More messages wait for transmission |
| bit_tick | input | 1 | A bit position strobe is valid |
| field_sel | input | 2 | Frame field of the tick: 1 End Of Frame, 2 intermission |
| bit_num | input | 3 | 1-based bit number inside the field |
| arb_lost | input | 1 | Arbitration lost |
| bus_idle | input | 1 | Bus idle detected |
| rx_start | input | 1 | Reception begins |
| halt_req | input | 1 | Halt entered |
| status | output | 4 | {bus_off, warning, tx_idle, in_reset} |
| tec_view | output | 8 | Lower 8 bits of transmit counter |
| rec_view | output | 8 | Receive counter |
| tx_ack | output | 1 | Transmit acknowledge pulse |

## Verification
The assertions take each event input as a strobe that lasts a single cycle. They also take the protocol engine to raise `bit_tick` only with a meaningful `field_sel`/`bit_num` pair, and to avoid starting a transmission in the same cycle as a forced-idle event. The stimulus drives every strobe for exactly one cycle, starting at a falling edge, and never combines `tx_start` with arbitration loss, bus idle, reception or halt. Recovery is exercised with a clean train of single-cycle `rec11_seen` pulses.

// File: rtl/can_fs_pkg.sv
package can_fs_pkg;

  typedef enum logic [1:0] {
    FLD_OTHER = 2'd0,
    FLD_EOF   = 2'd1,
    FLD_IFS   = 2'd2,
    FLD_SPARE = 2'd3
  } fld_e;

  typedef struct packed {
    logic bus_off;
    logic warn;
    logic tx_idle;
    logic in_reset;
  } stat_t;

endpackage

// File: rtl/can_fs_mode.sv
module can_fs_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic init_done,
  output logic in_reset
);

  logic in_reset_q;
  logic in_reset_d;

  always_comb begin
    in_reset_d = in_reset_q;
    if (sw_reset) begin
      in_reset_d = 1'b1;
    end else if (init_done) begin
      in_reset_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset_q <= 1'b1;
    end else begin
      in_reset_q <= in_reset_d;
    end
  end

  assign in_reset = in_reset_q;

  // R12
  sw_to_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> in_reset_q);

  // R1
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset_q && !init_done) |=> in_reset_q);

endmodule

// File: rtl/can_fs_counters.sv
module can_fs_counters #(
  parameter int TEC_W        = 9,
  parameter int REC_W        = 8,
  parameter int AMT_W        = 4,
  parameter int WARN_LIMIT   = 96,
  parameter int RECOVER_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             hold,
  input  logic             tx_inc_en,
  input  logic [AMT_W-1:0] tx_inc_amt,
  input  logic             tx_dec,
  input  logic             rx_inc_en,
  input  logic [AMT_W-1:0] rx_inc_amt,
  input  logic             rx_dec,
  input  logic             rec11_seen,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic             bus_off,
  output logic             warn
);

  localparam int TSUM_W = TEC_W + 1;
  localparam int RSUM_W = REC_W + 1;
  localparam logic [TEC_W-1:0]  TEC_OFF  = {1'b1, {(TEC_W-1){1'b0}}};
  localparam logic [TSUM_W-1:0] TEC_OFFX = {2'b01, {(TEC_W-1){1'b0}}};
  localparam logic [REC_W-1:0]  REC_MAX  = {REC_W{1'b1}};
  localparam logic [RSUM_W-1:0] REC_MAXX = {1'b0, {REC_W{1'b1}}};
  localparam logic [TEC_W-1:0]  WARN_T   = TEC_W'(WARN_LIMIT);
  localparam logic [REC_W-1:0]  WARN_R   = REC_W'(WARN_LIMIT);
  localparam logic [REC_W-1:0]  RECOV    = REC_W'(RECOVER_RUNS);

  logic [TEC_W-1:0]  tec_q, tec_d;
  logic [REC_W-1:0]  rec_q, rec_d;
  logic [TSUM_W-1:0] tec_sum;
  logic [RSUM_W-1:0] rec_sum;
  logic [REC_W-1:0]  rec_run;
  logic              off_q;
  logic              cnt_en;

  assign off_q   = tec_q[TEC_W-1];
  assign tec_sum = {1'b0, tec_q} + TSUM_W'(tx_inc_amt);
  assign rec_sum = {1'b0, rec_q} + RSUM_W'(rx_inc_amt);
  assign rec_run = rec_q + REC_W'(1);
  assign cnt_en  = sw_reset | hold | (off_q ? rec11_seen
                 : (tx_inc_en | tx_dec | rx_inc_en | rx_dec));

  always_comb begin
    tec_d = tec_q;
    rec_d = rec_q;
    if (sw_reset || hold) begin
      tec_d = '0;
      rec_d = '0;
    end else if (off_q) begin
      if (rec11_seen) begin
        if (rec_run >= RECOV) begin
          tec_d = '0;
          rec_d = '0;
        end else begin
          rec_d = rec_run;
        end
      end
    end else begin
      if (tx_inc_en) begin
        tec_d = (tec_sum >= TEC_OFFX) ? TEC_OFF : tec_sum[TEC_W-1:0];
      end else if (tx_dec && (tec_q != '0)) begin
        tec_d = tec_q - TEC_W'(1);
      end
      if (rx_inc_en) begin
        rec_d = (rec_sum > REC_MAXX) ? REC_MAX : rec_sum[REC_W-1:0];
      end else if (rx_dec && (rec_q != '0)) begin
        rec_d = rec_q - REC_W'(1);
      end
      if (tec_d[TEC_W-1]) begin
        rec_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (cnt_en) begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  assign tec     = tec_q;
  assign rec     = rec_q;
  assign bus_off = off_q;
  assign warn    = !off_q && ((tec_q >= WARN_T) || (rec_q >= WARN_R));

  // R9
  tec_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tec_q <= TEC_OFF);

  // R9
  off_entry_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_q) |-> (rec_q == '0));

  // R10
  off_rec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && $past(off_q)) |->
      ((rec_q == $past(rec_q)) || (rec_q == $past(rec_q) + REC_W'(1))));

  // R11
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_q) |-> ((rec_q == '0) && (tec_q == '0)));

endmodule

// File: rtl/can_fs_activity.sv
module can_fs_activity
  import can_fs_pkg::*;
#(
  parameter int BN_W     = 3,
  parameter int ACK_BIT  = 7,
  parameter int IDLE_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_reset,
  input  logic            hold,
  input  logic            bus_off,
  input  logic            tx_start,
  input  logic            tx_pending,
  input  logic            bit_tick,
  input  fld_e            field,
  input  logic [BN_W-1:0] bit_num,
  input  logic            arb_lost,
  input  logic            bus_idle,
  input  logic            rx_start,
  input  logic            halt_req,
  output logic            tx_busy,
  output logic            tx_ack
);

  localparam logic [BN_W-1:0] ACK_POS  = BN_W'(ACK_BIT);
  localparam logic [BN_W-1:0] IDLE_POS = BN_W'(IDLE_BIT);

  logic busy_q, busy_d;
  logic ack_q, ack_d;
  logic eof_hit, ifs_hit, forced, quiet;

  assign eof_hit = bit_tick && (field == FLD_EOF) && (bit_num == ACK_POS);
  assign ifs_hit = bit_tick && (field == FLD_IFS) && (bit_num == IDLE_POS);
  assign forced  = arb_lost | bus_idle | rx_start | halt_req;
  assign quiet   = sw_reset | hold | bus_off;

  always_comb begin
    busy_d = busy_q;
    if (quiet || forced) begin
      busy_d = 1'b0;
    end else if (ifs_hit && !tx_pending) begin
      busy_d = 1'b0;
    end else if (tx_start) begin
      busy_d = 1'b1;
    end
  end

  always_comb begin
    ack_d = !quiet && busy_q && eof_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ack_q  <= ack_d;
    end
  end

  assign tx_busy = busy_q;
  assign tx_ack  = ack_q;

  // R4
  ack_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(bit_tick && (field == FLD_EOF) && (bit_num == ACK_POS)));

  // R5
  idle_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tx_pending && ifs_hit) |=> !busy_q);

  // R6
  force_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> !busy_q);

endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import can_fs_pkg::*;
#(
  parameter int TEC_W        = 9,
  parameter int REC_W        = 8,
  parameter int AMT_W        = 4,
  parameter int BN_W         = 3,
  parameter int WARN_LIMIT   = 96,
  parameter int RECOVER_RUNS = 128,
  parameter int ACK_BIT      = 7,
  parameter int IDLE_BIT     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             init_done,
  input  logic             tx_inc_en,
  input  logic [AMT_W-1:0] tx_inc_amt,
  input  logic             tx_dec,
  input  logic             rx_inc_en,
  input  logic [AMT_W-1:0] rx_inc_amt,
  input  logic             rx_dec,
  input  logic             rec11_seen,
  input  logic             tx_start,
  input  logic             tx_pending,
  input  logic             bit_tick,
  input  logic [1:0]       field_sel,
  input  logic [BN_W-1:0]  bit_num,
  input  logic             arb_lost,
  input  logic             bus_idle,
  input  logic             rx_start,
  input  logic             halt_req,
  output logic [3:0]       status,
  output logic [7:0]       tec_view,
  output logic [7:0]       rec_view,
  output logic             tx_ack
);

  logic             in_reset;
  logic [TEC_W-1:0] tec;
  logic [REC_W-1:0] rec;
  logic             bus_off;
  logic             warn;
  logic             tx_busy;
  stat_t            stat;

  can_fs_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_reset  (sw_reset),
    .init_done (init_done),
    .in_reset  (in_reset)
  );

  can_fs_counters #(
    .TEC_W        (TEC_W),
    .REC_W        (REC_W),
    .AMT_W        (AMT_W),
    .WARN_LIMIT   (WARN_LIMIT),
    .RECOVER_RUNS (RECOVER_RUNS)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .hold       (in_reset),
    .tx_inc_en  (tx_inc_en),
    .tx_inc_amt (tx_inc_amt),
    .tx_dec     (tx_dec),
    .rx_inc_en  (rx_inc_en),
    .rx_inc_amt (rx_inc_amt),
    .rx_dec     (rx_dec),
    .rec11_seen (rec11_seen),
    .tec        (tec),
    .rec        (rec),
    .bus_off    (bus_off),
    .warn       (warn)
  );

  can_fs_activity #(
    .BN_W     (BN_W),
    .ACK_BIT  (ACK_BIT),
    .IDLE_BIT (IDLE_BIT)
  ) u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .hold       (in_reset),
    .bus_off    (bus_off),
    .tx_start   (tx_start),
    .tx_pending (tx_pending),
    .bit_tick   (bit_tick),
    .field      (fld_e'(field_sel)),
    .bit_num    (bit_num),
    .arb_lost   (arb_lost),
    .bus_idle   (bus_idle),
    .rx_start   (rx_start),
    .halt_req   (halt_req),
    .tx_busy    (tx_busy),
    .tx_ack     (tx_ack)
  );

  always_comb begin
    stat.in_reset = in_reset;
    stat.tx_idle  = !bus_off && !tx_busy;
    stat.warn     = warn;
    stat.bus_off  = bus_off;
  end

  assign status   = stat;
  assign tec_view = tec[7:0];
  assign rec_view = 8'(rec);

  // R9
  off_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> !status[1]);

endmodule

// File: tb/can_fault_status_tb.sv
module can_fault_status_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_reset, init_done;
  logic       tx_inc_en, tx_dec, rx_inc_en, rx_dec;
  logic [3:0] tx_inc_amt, rx_inc_amt;
  logic       rec11_seen, tx_start, tx_pending, bit_tick;
  logic [1:0] field_sel;
  logic [2:0] bit_num;
  logic       arb_lost, bus_idle, rx_start, halt_req;
  logic [3:0] status;
  logic [7:0] tec_view, rec_view;
  logic       tx_ack;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  can_fault_status dut_i (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .init_done(init_done),
    .tx_inc_en(tx_inc_en), .tx_inc_amt(tx_inc_amt), .tx_dec(tx_dec),
    .rx_inc_en(rx_inc_en), .rx_inc_amt(rx_inc_amt), .rx_dec(rx_dec),
    .rec11_seen(rec11_seen), .tx_start(tx_start), .tx_pending(tx_pending),
    .bit_tick(bit_tick), .field_sel(field_sel), .bit_num(bit_num),
    .arb_lost(arb_lost), .bus_idle(bus_idle), .rx_start(rx_start),
    .halt_req(halt_req), .status(status), .tec_view(tec_view),
    .rec_view(rec_view), .tx_ack(tx_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_reset = 0; init_done = 0; tx_inc_en = 0; tx_dec = 0; rx_inc_en = 0;
    rx_dec = 0; tx_inc_amt = 0; rx_inc_amt = 0; rec11_seen = 0; tx_start = 0;
    bit_tick = 0; field_sel = 0; bit_num = 0; arb_lost = 0;
    bus_idle = 0; rx_start = 0; halt_req = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic restart();
    sw_reset = 1; step();
    init_done = 1; step();
  endtask

  task automatic tick(input logic [1:0] f, input logic [2:0] n);
    bit_tick = 1; field_sel = f; bit_num = n; step();
  endtask

  task automatic tx_add(input logic [3:0] a, input int times);
    for (int i = 0; i < times; i++) begin
      tx_inc_en = 1; tx_inc_amt = a; step();
    end
  endtask

  task automatic rx_add(input logic [3:0] a, input int times);
    for (int i = 0; i < times; i++) begin
      rx_inc_en = 1; rx_inc_amt = a; step();
    end
  endtask

  task automatic runs(input int times);
    for (int i = 0; i < times; i++) begin
      rec11_seen = 1; step();
    end
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status, 4'b0011);
    chk("R2 tec_view after reset", tec_view, 0);
    chk("R2 rec_view after reset", rec_view, 0);
    chk("R4 no ack after reset", tx_ack, 0);
    tx_add(8, 1);
    chk("R1 inc ignored in reset", tec_view, 0);
    tx_start = 1; step();
    chk("R1 tx_start ignored in reset", status, 4'b0011);
    init_done = 1; step();
    chk("R1 init_done leaves reset", status, 4'b0010);
  endtask

  task automatic t_tx();
    tx_start = 1; step();
    chk("R3 busy after tx_start", status, 4'b0000);
    tick(2'd1, 3'd6);
    chk("R4 no ack at bit 6", tx_ack, 0);
    tick(2'd1, 3'd7);
    chk("R4 ack at bit 7", tx_ack, 1);
    chk("R5 still busy after ack", status[1], 0);
    step();
    chk("R4 ack one cycle", tx_ack, 0);
    tx_pending = 1; tick(2'd2, 3'd3);
    chk("R5 pending keeps busy", status[1], 0);
    tx_pending = 0; tick(2'd2, 3'd2);
    chk("R5 bit 2 keeps busy", status[1], 0);
    tick(2'd2, 3'd3);
    chk("R5 idle at bit 3", status, 4'b0010);
  endtask

  task automatic t_force();
    for (int k = 0; k < 4; k++) begin
      tx_start = 1; step();
      chk("R3 busy before force", status[1], 0);
      case (k)
        0: arb_lost = 1;
        1: bus_idle = 1;
        2: rx_start = 1;
        default: halt_req = 1;
      endcase
      step();
      chk("R6 forced idle", status[1], 1);
    end
    tx_start = 1; step();
    tx_add(8, 1);
    chk("R3 busy through error", status[1], 0);
    chk("R7 tec after inc", tec_view, 8);
    restart();
    chk("R12 restart clears tec", tec_view, 0);
  endtask

  task automatic t_count();
    tx_add(8, 11);
    chk("R8 no warn at 88", status[2], 0);
    tx_add(8, 1);
    chk("R8 warn at 96", status[2], 1);
    tx_dec = 1; step();
    chk("R7 tec dec", tec_view, 95);
    chk("R8 warn off at 95", status[2], 0);
    rx_add(15, 7);
    chk("R8 warn from rec", status[2], 1);
    rx_inc_en = 1; rx_inc_amt = 1; rx_dec = 1; step();
    chk("R7 inc wins over dec", rec_view, 106);
    rx_add(15, 20);
    chk("R7 rec saturates", rec_view, 255);
    restart();
    rx_dec = 1; tx_dec = 1; step();
    chk("R7 rec floor", rec_view, 0);
    chk("R7 tec floor", tec_view, 0);
  endtask

  task automatic t_busoff();
    tx_add(15, 17);
    chk("R2 tec_view 255", tec_view, 255);
    chk("R8 warn near off", status, 4'b0110);
    rx_add(8, 1);
    tx_add(1, 1);
    chk("R9 bus off status", status, 4'b1000);
    chk("R9 tec_view wraps", tec_view, 0);
    chk("R9 rec cleared", rec_view, 0);
    tx_add(8, 1); rx_add(8, 1); tx_dec = 1; step();
    chk("R9 rec frozen", rec_view, 0);
    chk("R9 still off", status[3], 1);
    tx_start = 1; step();
    chk("R9 idle low in off", status[1], 0);
    runs(96);
    chk("R10 rec counts runs", rec_view, 96);
    chk("R10 warn held low", status, 4'b1000);
    runs(31);
    chk("R11 not yet recovered", status[3], 1);
    runs(1);
    chk("R11 recovered status", status, 4'b0010);
    chk("R11 tec zero", tec_view, 0);
    chk("R11 rec zero", rec_view, 0);
  endtask

  task automatic t_sw_off();
    tx_add(15, 18);
    chk("R9 off again", status[3], 1);
    runs(5);
    sw_reset = 1; rec11_seen = 1; step();
    chk("R12 sw_reset wins", status, 4'b0011);
    chk("R12 rec cleared", rec_view, 0);
    init_done = 1; step();
    chk("R1 out of reset", status, 4'b0010);
  endtask

  initial begin
    idle_inputs();
    tx_pending = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_tx();
    t_force();
    t_count();
    t_busoff();
    t_sw_off();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule